// File: doc/BRIEF.md
# Framer Alarm and Event Interrupt Status

This block gathers seven status conditions from a line framer and turns them into one interrupt. Five of the inputs are alarm levels: loss of signal, loss of frame, alarm indication signal (AIS), remote alarm and idle. Each alarm passes through a synchronizer. Any transition of a synchronized alarm, rising or falling, sets a sticky status bit. The other two inputs are one-cycle pulses, one for receive start of frame and one for transmit start of frame. These are already in the block's clock domain, and each sets its sticky bit directly.

A per-bit enable register selects which sticky bits can raise the interrupt. The enabled bits are ORed into a summary flag. A single master enable gates that flag, and the result drives an active-low interrupt line.

Software uses a small register port. Read data is combinational and valid in the same cycle as the read strobe. A read of the status register returns the sticky bits and clears all of them at the next clock edge. If a new event arrives in that same cycle, the new event is kept.

Top module: `alarm_irq_status`

## Requirements
- R1: Status register (address 0) bit positions: bit 0 loss of signal (alarm_in[0]), bit 1 loss of frame (alarm_in[1]), bit 2 AIS (alarm_in[2]), bit 3 remote alarm (alarm_in[3]), bit 4 idle (alarm_in[4]), bit 5 receive start of frame, bit 6 transmit start of frame. Bits 15:7 read as zero.
- R2: A rising transition on an alarm input sets its sticky bit. The bit becomes visible after the third rising clock edge that samples the new level (two synchronizer flops plus the latch).
- R3: A falling transition on an alarm input also sets its sticky bit, with the same latency as R2.
- R4: A one-cycle pulse on rx_sof or tx_sof sets status bit 5 or bit 6 at the next clock edge.
- R5: A read of address 0 returns the sticky bits and clears all seven at that clock edge. A level that stays constant does not set its bit again, so the register reports latched history and not live levels.
- R6: If a bit's set condition occurs in the same cycle as a clearing read, the bit is set after that edge.
- R7: The per-bit enable register (address 1, bits 6:0, same positions as R1) decides which sticky bits take part in the interrupt.
- R8: Master status register (address 2) bit 9 is the OR of all enabled sticky bits. All its other bits read as zero.
- R9: irq_n is low exactly when master status bit 9 is set and master enable bit 9 (address 3) is set. Otherwise it is high.
- R10: After reset, all sticky bits and both enable registers are zero, and irq_n is high.
- R11: Both enable registers can be read and written. Bits that do not exist read back as zero.
- R12: Writes to address 0 and to address 2 have no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alarm_in | input | 5 | Alarm levels, not synchronized; bit order as in R1 |
| rx_sof | input | 1 | Receive start-of-frame pulse, synchronous, one cycle |
| tx_sof | input | 1 | Transmit start-of-frame pulse, synchronous, one cycle |
| reg_addr | input | 2 | Register select: 0 status, 1 enable, 2 master status, 3 master enable |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data for the selected register |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The assertions check on every cycle that:
- sticky bits never drop except on a clearing read;
- a clearing read leaves exactly the bits whose set condition was present in that cycle;
- a start-of-frame pulse is latched at the next edge;
- the enable register changes only on a write to its own address;
- the interrupt stays high while no bit is latched.

The bench's scenarios show the rest:
- the three-edge latency from an alarm input change to the status bit, for both edge directions;
- the bit positions;
- the masking through both levels;
- the collision between a read and a pulse.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;
  localparam int NUM_ALARMS  = 5;
  localparam int NUM_EVENTS  = 2;
  localparam int NUM_STATUS  = NUM_ALARMS + NUM_EVENTS;
  localparam int REG_DW      = 16;
  localparam int ADDR_W      = 2;
  localparam int SUMMARY_BIT = 9;

  typedef enum logic [ADDR_W-1:0] {
    REG_STATUS      = 2'd0,
    REG_STAT_EN     = 2'd1,
    REG_MASTER      = 2'd2,
    REG_MASTER_EN   = 2'd3
  } reg_addr_e;

  // set vector: alarms in the low bits, then rx start, then tx start
  function automatic logic [NUM_STATUS-1:0] build_set(
    input logic [NUM_ALARMS-1:0] chg,
    input logic rx_ev,
    input logic tx_ev);
    return {tx_ev, rx_ev, chg};
  endfunction

  // clear-on-read with set priority
  function automatic logic [NUM_STATUS-1:0] latch_next(
    input logic [NUM_STATUS-1:0] cur,
    input logic [NUM_STATUS-1:0] set,
    input logic                  clr);
    return clr ? set : (cur | set);
  endfunction

  function automatic logic any_enabled(
    input logic [NUM_STATUS-1:0] lat,
    input logic [NUM_STATUS-1:0] en);
    return |(lat & en);
  endfunction
endpackage

// File: rtl/alarm_edge_detect.sv
module alarm_edge_detect #(
  parameter int N      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] level,
  output logic [N-1:0] chg
);
  localparam int LAST = STAGES - 1;

  logic [N-1:0] stage_q [STAGES];
  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
      prev_q <= '0;
    end else begin
      stage_q[0] <= async_in;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      prev_q <= stage_q[LAST];
    end
  end

  assign level = stage_q[LAST];
  assign chg   = level ^ prev_q;

  // R3
  chg_clears_after_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chg != '0) |=> (prev_q == $past(level)));
endmodule

// File: rtl/sticky_status_bank.sv
module sticky_status_bank
  import alarm_irq_pkg::*;
#(
  parameter int NB = NUM_STATUS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] set_vec,
  input  logic          clr,
  output logic [NB-1:0] lat
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat <= '0;
    else        lat <= latch_next(lat, set_vec, clr);
  end

  // R2
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((lat & $past(lat)) == $past(lat)));

  // R5
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (lat == $past(set_vec)));

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((lat & $past(set_vec)) == $past(set_vec)));
endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
  import alarm_irq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_STATUS-1:0] lat,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  rd,
  input  logic                  wr,
  input  logic [REG_DW-1:0]     wdata,
  output logic [REG_DW-1:0]     rdata,
  output logic                  stat_clr,
  output logic                  summary,
  output logic                  irq_n
);
  logic [NUM_STATUS-1:0] stat_en_q;
  logic                  master_en_q;
  logic                  wr_stat_en;
  logic                  wr_master_en;
  logic                  unused_wdata;

  assign wr_stat_en   = wr && (addr == REG_STAT_EN);
  assign wr_master_en = wr && (addr == REG_MASTER_EN);
  assign stat_clr     = rd && (addr == REG_STATUS);
  assign unused_wdata = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_en_q   <= '0;
      master_en_q <= 1'b0;
    end else begin
      if (wr_stat_en)   stat_en_q   <= wdata[NUM_STATUS-1:0];
      if (wr_master_en) master_en_q <= wdata[SUMMARY_BIT];
    end
  end

  assign summary = any_enabled(lat, stat_en_q);
  assign irq_n   = ~(summary & master_en_q);

  always_comb begin
    rdata = '0;
    case (addr)
      REG_STATUS:    rdata[NUM_STATUS-1:0] = lat;
      REG_STAT_EN:   rdata[NUM_STATUS-1:0] = stat_en_q;
      REG_MASTER:    rdata[SUMMARY_BIT]    = summary;
      REG_MASTER_EN: rdata[SUMMARY_BIT]    = master_en_q;
      default:       rdata = '0;
    endcase
  end

  // R12
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stat_en |=> $stable(stat_en_q));

  // R11
  master_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_master_en |=> $stable(master_en_q));
endmodule

// File: rtl/alarm_irq_status.sv
module alarm_irq_status
  import alarm_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_ALARMS-1:0] alarm_in,
  input  logic                  rx_sof,
  input  logic                  tx_sof,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic                  reg_rd,
  input  logic                  reg_wr,
  input  logic [REG_DW-1:0]     reg_wdata,
  output logic [REG_DW-1:0]     reg_rdata,
  output logic                  irq_n
);
  logic [NUM_ALARMS-1:0] alarm_level;
  logic [NUM_ALARMS-1:0] alarm_chg;
  logic [NUM_STATUS-1:0] set_vec;
  logic [NUM_STATUS-1:0] status_lat;
  logic                  stat_clr;
  logic                  summary;

  alarm_edge_detect #(.N(NUM_ALARMS), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (alarm_in),
    .level    (alarm_level),
    .chg      (alarm_chg)
  );

  assign set_vec = build_set(alarm_chg, rx_sof, tx_sof);

  sticky_status_bank #(.NB(NUM_STATUS)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr     (stat_clr),
    .lat     (status_lat)
  );

  irq_reg_port u_port (
    .clk      (clk),
    .rst_n    (rst_n),
    .lat      (status_lat),
    .addr     (reg_addr),
    .rd       (reg_rd),
    .wr       (reg_wr),
    .wdata    (reg_wdata),
    .rdata    (reg_rdata),
    .stat_clr (stat_clr),
    .summary  (summary),
    .irq_n    (irq_n)
  );

  // R4
  rx_sof_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_sof |=> status_lat[NUM_ALARMS]);

  // R4
  tx_sof_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_sof |=> status_lat[NUM_ALARMS+1]);

  // R9
  quiet_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_lat == '0) |-> irq_n);

  // R8
  summary_needs_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    summary |-> (status_lat != '0));
endmodule

// File: tb/alarm_irq_status_test.sv
`timescale 1ns/1ps
module alarm_irq_status_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  alarm_in = '0;
  logic        rx_sof = 1'b0;
  logic        tx_sof = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic        reg_rd = 1'b0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq_n;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  always #10 clk = ~clk;

  alarm_irq_status uut (
    .clk(clk), .rst_n(rst_n), .alarm_in(alarm_in), .rx_sof(rx_sof),
    .tx_sof(tx_sof), .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_n(irq_n)
  );

  // behavioural reference: queue holds [previous, synced, first stage]
  int unsigned hist[$];
  int unsigned m_lat, m_en, m_men;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = '{0, 0, 0};
      m_lat = 0; m_en = 0; m_men = 0;
    end else begin
      int unsigned setv;
      setv = (hist[1] ^ hist[0]) | (int'(rx_sof) << 5) | (int'(tx_sof) << 6);
      if (reg_rd && reg_addr == 2'd0) m_lat = setv;
      else                            m_lat = m_lat | setv;
      if (reg_wr && reg_addr == 2'd1) m_en  = reg_wdata & 16'h7F;
      if (reg_wr && reg_addr == 2'd3) m_men = reg_wdata[9];
      hist.push_back(alarm_in);
      void'(hist.pop_front());
    end
  end

  function automatic logic [15:0] model_read(input logic [1:0] a);
    case (a)
      2'd0: return m_lat[15:0];
      2'd1: return m_en[15:0];
      2'd2: return ((m_lat & m_en) != 0) ? 16'h0200 : 16'h0000;
      default: return m_men ? 16'h0200 : 16'h0000;
    endcase
  endfunction

  function automatic logic model_irq_n();
    return !(((m_lat & m_en) != 0) && (m_men != 0));
  endfunction

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R9 compared with the model on every clock
  always @(negedge clk) begin
    if (!done) begin
      #5;
      check({15'b0, irq_n}, {15'b0, model_irq_n()}, "R9 per-cycle irq_n");
    end
  end

  task automatic do_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic do_read(input logic [1:0] a, input logic [15:0] lit, input string tag);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #5;
    check(reg_rdata, model_read(a), {tag, " (model)"});
    check(reg_rdata, lit, tag);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic pulse_rx(); @(negedge clk); rx_sof = 1; @(negedge clk); rx_sof = 0; endtask
  task automatic pulse_tx(); @(negedge clk); tx_sof = 1; @(negedge clk); tx_sof = 0; endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R10 reset state
    do_read(2'd0, 16'h0000, "R10 status after reset");
    do_read(2'd1, 16'h0000, "R10 enable after reset");
    do_read(2'd3, 16'h0000, "R10 master enable after reset");
    check({15'b0, irq_n}, 16'h0001, "R10 irq_n high after reset");

    // R11 enable registers read back, absent bits zero
    do_write(2'd1, 16'hFFFF);
    do_read(2'd1, 16'h007F, "R11 enable readback");
    do_write(2'd3, 16'hFFFF);
    do_read(2'd3, 16'h0200, "R11 master enable readback");

    // R2 rising edge latency on loss of signal
    @(negedge clk); alarm_in = 5'b00001;
    @(negedge clk); #5; check({15'b0, irq_n}, 16'h0001, "R2 no latch after edge 1");
    @(negedge clk); #5; check({15'b0, irq_n}, 16'h0001, "R2 no latch after edge 2");
    @(negedge clk); #5; check({15'b0, irq_n}, 16'h0000, "R2 latched after edge 3");
    do_read(2'd0, 16'h0001, "R2 R1 LOS at bit 0");
    idle(4);
    do_read(2'd0, 16'h0000, "R5 cleared, steady level not relatched");
    // R3 falling edge
    @(negedge clk); alarm_in = 5'b00000;
    idle(4);
    do_read(2'd0, 16'h0001, "R3 falling edge latches");

    // R1 each alarm position
    for (int i = 1; i < 5; i++) begin
      @(negedge clk); alarm_in = 5'(1 << i);
      idle(4);
      do_read(2'd0, 16'(1 << i), "R1 alarm bit position");
      @(negedge clk); alarm_in = 5'b0;
      idle(4);
      do_read(2'd0, 16'(1 << i), "R3 alarm bit release");
    end

    // R4 start-of-frame events
    pulse_rx();
    do_read(2'd0, 16'h0020, "R4 R1 rx start at bit 5");
    pulse_tx();
    do_read(2'd0, 16'h0040, "R4 R1 tx start at bit 6");

    // R7 R8 per-bit enable and summary
    do_write(2'd1, 16'h0002);
    @(negedge clk); alarm_in = 5'b00001;
    idle(4);
    check({15'b0, irq_n}, 16'h0001, "R7 disabled bit keeps irq high");
    do_read(2'd2, 16'h0000, "R8 summary clear with disabled bit");
    @(negedge clk); alarm_in = 5'b00011;
    idle(4);
    check({15'b0, irq_n}, 16'h0000, "R7 enabled bit asserts irq");
    do_read(2'd2, 16'h0200, "R8 summary at bit 9");

    // R9 master enable gates the line
    do_write(2'd3, 16'h0000);
    idle(1);
    check({15'b0, irq_n}, 16'h0001, "R9 master enable off");
    do_write(2'd3, 16'h0200);
    idle(1);
    check({15'b0, irq_n}, 16'h0000, "R9 master enable on");
    do_read(2'd0, 16'h0003, "R5 status read returns latched bits");
    idle(1);
    check({15'b0, irq_n}, 16'h0001, "R5 read clears and releases irq");

    // R6 set in the same cycle as a clearing read
    do_write(2'd1, 16'h007F);
    pulse_tx();
    @(negedge clk);
    reg_addr = 2'd0; reg_rd = 1'b1; rx_sof = 1'b1;
    #5; check(reg_rdata, 16'h0040, "R6 read before collision");
    @(negedge clk);
    reg_rd = 1'b0; rx_sof = 1'b0;
    do_read(2'd0, 16'h0020, "R6 colliding event kept");

    // R12 writes to read-only addresses
    pulse_rx();
    do_write(2'd0, 16'h0000);
    do_write(2'd2, 16'h0000);
    do_read(2'd1, 16'h007F, "R12 enable unchanged");
    do_read(2'd3, 16'h0200, "R12 master enable unchanged");
    do_read(2'd0, 16'h0020, "R12 status unchanged by write");

    idle(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule